// File: doc/BRIEF.md
# Double-Buffered DAC Input Register

This block is the digital front end of a 12-bit digital-to-analog converter. Incoming data is staged in a first rank of three 4-bit holding registers. A separate second-rank 12-bit register then takes the whole word at once and drives the converter code. Because of this split, a host can assemble a new word piece by piece while the converter keeps its previous value, and then switch to the new value in one step.

Register selection uses an active-low chip select and one active-low enable line per register. The enables are qualified by a write strobe and sampled on the rising clock edge. The strobe and chip select are plain levels sampled at that edge, not latch timing.

A build parameter selects the host side. With a 12-bit host port, the data is written through the nibble enables. With an 8-bit host bus, the host writes two bytes, and a mode input chooses the left-justified or the right-justified byte layout.

At each second-rank load, an input can flip bit 11 of the stored code. This turns two's complement data into the offset binary code that a bipolar converter expects. With the input low, the code stays straight binary for unipolar use.

Top module: `dbuf_dac_front`

## Requirements
- R1: While reset (`rst_n` low) is applied, and after it is released, the first rank and `dac_code` hold 000h.
- R2: When `cs_n` is high, or `wr_stb` is low at a clock edge, no register changes, whatever `addr_n` and `wdata` carry.
- R3: 12-bit host: with `cs_n` low and `wr_stb` high, each low enable line loads one first-rank nibble. `addr_n[0]` loads from `wdata[3:0]`, `addr_n[1]` from `wdata[7:4]` and `addr_n[2]` from `wdata[11:8]`. `dac_code` does not change unless `addr_n[3]` is also low.
- R4: 12-bit host: `addr_n[3]` low (with `cs_n` low and `wr_stb` high) copies the first rank into `dac_code`. The new value appears after that clock edge. A write with all four enable lines high changes nothing.
- R5: Enables combine freely within one write. A nibble loaded in the same write as the second rank reaches `dac_code` in that write. With `addr_n` = 0000, `wdata` reaches `dac_code` in one write.
- R6: At a second-rank load, `twos_comp` = 1 stores the word with bit 11 inverted (for example, 123h becomes 923h and 800h becomes 000h). `twos_comp` = 0 stores the word unchanged.
- R7: 8-bit host, `right_just` = 0 (left-justified): offset `addr_n[1:0]` = 01 loads byte bits [7:4] into code bits [3:0]. Offset 10 loads the byte into code bits [11:4] and, in the same write, loads the second rank.
- R8: 8-bit host, `right_just` = 1 (right-justified): offset 01 loads the byte into code bits [7:0]. Offset 10 loads byte bits [3:0] into code bits [11:8] and, in the same write, loads the second rank. Byte bits [7:4] are ignored at offset 10.
- R9: 8-bit host: offsets 00 and 11 change no register, and `addr_n[3:2]` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears both ranks |
| wr_stb | input | 1 | Write strobe, active high, sampled at the clock edge |
| cs_n | input | 1 | Chip select, active low |
| addr_n | input | NUM_NIB+1 (4) | 12-bit host: per-register enables, active low. 8-bit host: bits [1:0] form the byte offset |
| wdata | input | HOST_W (12 or 8) | Write data from the host |
| right_just | input | 1 | Byte layout on the 8-bit host: 0 left-justified, 1 right-justified; unused on the 12-bit host |
| twos_comp | input | 1 | 1 inverts bit 11 at the second-rank load |
| dac_code | output | NUM_NIB*NIB_W (12) | Second-rank code driving the converter |

## Verification
The bench builds two copies of the block side by side. One uses the default `HOST_W` = 12, which exercises the individual nibble enables, combined enables, pass-through and the inversion of bit 11. The other uses `HOST_W` = 8, which exercises both byte layouts, the ignored offsets and the ignored upper address lines. Directed sequences place data in unselected nibbles and in the unused half of the byte, so that a wrong slice or a wrong enable shows up in `dac_code`. Random writes across all address patterns, both layouts and both coding modes are then compared against a model kept in the bench.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;

   typedef enum logic {
      JUST_LEFT  = 1'b0,
      JUST_RIGHT = 1'b1
   } just_e;

   localparam int BYTE_W      = 8;
   localparam int BYTE_NIB_W  = 4;
   localparam int BYTE_NUM_NB = 3;

endpackage

// File: rtl/dac_wr_decode.sv
module dac_wr_decode
   import dac_front_pkg::*;
#(
   parameter int NIB_W   = 4,
   parameter int NUM_NIB = 3,
   parameter int HOST_W  = 12
) (
   input  logic                        wr_stb,
   input  logic                        cs_n,
   input  logic [NUM_NIB:0]            addr_n,
   input  logic [HOST_W-1:0]           wdata,
   input  logic                        right_just,
   output logic [NUM_NIB-1:0]          nib_en,
   output logic [NIB_W*NUM_NIB-1:0]    nib_data,
   output logic                        load_out
);
   localparam int CODE_W = NIB_W * NUM_NIB;

   logic act;
   assign act = wr_stb & ~cs_n;

   if (HOST_W == CODE_W) begin : g_wide
      for (genvar i = 0; i < NUM_NIB; i++) begin : g_en
         assign nib_en[i] = act & ~addr_n[i];
      end
      assign nib_data = wdata;
      assign load_out = act & ~addr_n[NUM_NIB];
      logic unused_rj;
      assign unused_rj = right_just;
   end else if (HOST_W == BYTE_W && NIB_W == BYTE_NIB_W && NUM_NIB == BYTE_NUM_NB) begin : g_byte
      logic       sel_lo;
      logic       sel_hi;
      logic [2:0] en_b;
      logic [11:0] data_b;
      assign sel_lo = act & (addr_n[1:0] == 2'b01);
      assign sel_hi = act & (addr_n[1:0] == 2'b10);
      always_comb begin
         if (just_e'(right_just) == JUST_RIGHT) begin
            en_b   = {sel_hi, sel_lo, sel_lo};
            data_b = {wdata[3:0], wdata[7:0]};
         end else begin
            en_b   = {sel_hi, sel_hi, sel_lo};
            data_b = {wdata[7:0], wdata[7:4]};
         end
      end
      assign nib_en   = en_b;
      assign nib_data = data_b;
      assign load_out = sel_hi;
      logic unused_hi_addr;
      assign unused_hi_addr = ^addr_n[NUM_NIB:2];
   end else begin : g_bad_host
      $error("dac_wr_decode: HOST_W must equal NIB_W*NUM_NIB or be 8 with a 3x4-bit code");
   end

endmodule

// File: rtl/dac_first_rank.sv
module dac_first_rank #(
   parameter int NIB_W   = 4,
   parameter int NUM_NIB = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_NIB-1:0]        nib_en,
   input  logic [NIB_W*NUM_NIB-1:0]  nib_data,
   output logic [NIB_W*NUM_NIB-1:0]  r1_next
);

   for (genvar i = 0; i < NUM_NIB; i++) begin : g_nib
      logic [NIB_W-1:0] hold_q;
      logic [NIB_W-1:0] fresh;
      assign fresh = nib_data[i*NIB_W +: NIB_W];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            hold_q <= '0;
         else if (nib_en[i])
            hold_q <= fresh;
      end

      // Value the nibble holds after this edge; lets the second rank
      // capture a nibble written in the same cycle.
      assign r1_next[i*NIB_W +: NIB_W] = nib_en[i] ? fresh : hold_q;
   end

endmodule

// File: rtl/dac_second_rank.sv
module dac_second_rank #(
   parameter int CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              twos_comp,
   input  logic [CODE_W-1:0] r1_next,
   output logic [CODE_W-1:0] code_q
);
   logic [CODE_W-1:0] msb_flip;
   assign msb_flip = {twos_comp, {(CODE_W-1){1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         code_q <= '0;
      else if (load)
         code_q <= r1_next ^ msb_flip;
   end

endmodule

// File: rtl/dbuf_dac_front.sv
module dbuf_dac_front #(
   parameter int NIB_W   = 4,
   parameter int NUM_NIB = 3,
   parameter int HOST_W  = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_stb,
   input  logic                       cs_n,
   input  logic [NUM_NIB:0]           addr_n,
   input  logic [HOST_W-1:0]          wdata,
   input  logic                       right_just,
   input  logic                       twos_comp,
   output logic [NIB_W*NUM_NIB-1:0]   dac_code
);
   localparam int CODE_W = NIB_W * NUM_NIB;

   if (NIB_W < 1 || NUM_NIB < 2) begin : g_bad_shape
      $error("dbuf_dac_front: need NIB_W >= 1 and NUM_NIB >= 2");
   end
   if (HOST_W != CODE_W && HOST_W != 8) begin : g_bad_host
      $error("dbuf_dac_front: HOST_W must be the code width or 8");
   end

   logic [NUM_NIB-1:0] w_nib_en;
   logic [CODE_W-1:0]  w_nib_data;
   logic [CODE_W-1:0]  w_r1_next;
   logic               w_load;

   dac_wr_decode #(
      .NIB_W   (NIB_W),
      .NUM_NIB (NUM_NIB),
      .HOST_W  (HOST_W)
   ) u_decode (
      .wr_stb     (wr_stb),
      .cs_n       (cs_n),
      .addr_n     (addr_n),
      .wdata      (wdata),
      .right_just (right_just),
      .nib_en     (w_nib_en),
      .nib_data   (w_nib_data),
      .load_out   (w_load)
   );

   dac_first_rank #(
      .NIB_W   (NIB_W),
      .NUM_NIB (NUM_NIB)
   ) u_rank1 (
      .clk      (clk),
      .rst_n    (rst_n),
      .nib_en   (w_nib_en),
      .nib_data (w_nib_data),
      .r1_next  (w_r1_next)
   );

   dac_second_rank #(
      .CODE_W (CODE_W)
   ) u_rank2 (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (w_load),
      .twos_comp (twos_comp),
      .r1_next   (w_r1_next),
      .code_q    (dac_code)
   );

endmodule

// File: rtl/dac_front_chk.sv
module dac_front_chk #(
   parameter int NIB_W   = 4,
   parameter int NUM_NIB = 3,
   parameter int HOST_W  = 12
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      wr_stb,
   input logic                      cs_n,
   input logic [NUM_NIB:0]          addr_n,
   input logic [HOST_W-1:0]         wdata,
   input logic                      twos_comp,
   input logic [NUM_NIB-1:0]        nib_en,
   input logic                      load2,
   input logic [NIB_W*NUM_NIB-1:0]  dac_code
);
   localparam int CODE_W = NIB_W * NUM_NIB;

   logic [CODE_W-1:0] flip;
   assign flip = {1'b1, {(CODE_W-1){1'b0}}};

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> dac_code == '0);

   assert_cs_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || !wr_stb) |-> (nib_en == '0 && !load2));

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !load2 |=> $stable(dac_code));

   if (HOST_W == CODE_W) begin : g_wide_chk
      assert_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_stb && !cs_n && addr_n == '0 && !twos_comp) |=> dac_code == $past(wdata));

      assert_twos_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_stb && !cs_n && addr_n == '0 && twos_comp) |=> dac_code == ($past(wdata) ^ flip));
   end else begin : g_byte_chk
      assert_byte_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_stb && !cs_n && addr_n[1:0] == 2'b10) |-> load2);

      assert_byte_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_stb && !cs_n && (addr_n[1:0] == 2'b00 || addr_n[1:0] == 2'b11))
            |-> (nib_en == '0 && !load2));

      logic unused_chk;
      assign unused_chk = ^{wdata, twos_comp, flip};
   end

endmodule

bind dbuf_dac_front dac_front_chk #(
   .NIB_W   (NIB_W),
   .NUM_NIB (NUM_NIB),
   .HOST_W  (HOST_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_stb    (wr_stb),
   .cs_n      (cs_n),
   .addr_n    (addr_n),
   .wdata     (wdata),
   .twos_comp (twos_comp),
   .nib_en    (w_nib_en),
   .load2     (w_load),
   .dac_code  (dac_code)
);

// File: tb/test_dbuf_dac_front.sv
module test_dbuf_dac_front;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic        n_wr = 0, n_cs = 1, n_rj = 0, n_tc = 0;
   logic [3:0]  n_addr = 4'hF;
   logic [11:0] n_data = '0;
   logic [11:0] n_code;

   logic        b_wr = 0, b_cs = 1, b_rj = 0, b_tc = 0;
   logic [3:0]  b_addr = 4'hF;
   logic [7:0]  b_data = '0;
   logic [11:0] b_code;

   dbuf_dac_front i_dbuf_dac_front (
      .clk(clk), .rst_n(rst_n), .wr_stb(n_wr), .cs_n(n_cs), .addr_n(n_addr),
      .wdata(n_data), .right_just(n_rj), .twos_comp(n_tc), .dac_code(n_code));

   dbuf_dac_front #(.HOST_W(8)) i_dbuf_dac_front_b8 (
      .clk(clk), .rst_n(rst_n), .wr_stb(b_wr), .cs_n(b_cs), .addr_n(b_addr),
      .wdata(b_data), .right_just(b_rj), .twos_comp(b_tc), .dac_code(b_code));

   int n_cmp = 0;
   int n_bad = 0;
   logic [11:0] nm1 = '0, nexp = '0, bm1 = '0, bexp = '0;

   task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic nwr(input logic cs, input logic [3:0] a, input logic [11:0] d,
                      input logic tc, input logic stb = 1'b1);
      @(negedge clk);
      n_wr = stb; n_cs = cs; n_addr = a; n_data = d; n_tc = tc;
      if (stb && !cs) begin
         for (int i = 0; i < 3; i++)
            if (!a[i]) nm1[i*4 +: 4] = d[i*4 +: 4];
         if (!a[3]) nexp = nm1 ^ {tc, 11'b0};
      end
      @(negedge clk);
      n_wr = 0; n_cs = 1; n_addr = 4'hF;
   endtask

   task automatic bwr(input logic cs, input logic [3:0] a, input logic [7:0] d,
                      input logic rj, input logic tc);
      @(negedge clk);
      b_wr = 1; b_cs = cs; b_addr = a; b_data = d; b_rj = rj; b_tc = tc;
      if (!cs) begin
         if (a[1:0] == 2'b01) begin
            if (rj) bm1[7:0] = d; else bm1[3:0] = d[7:4];
         end else if (a[1:0] == 2'b10) begin
            if (rj) bm1[11:8] = d[3:0]; else bm1[11:4] = d;
            bexp = bm1 ^ {tc, 11'b0};
         end
      end
      @(negedge clk);
      b_wr = 0; b_cs = 1; b_addr = 4'hF;
   endtask

   task automatic t_reset;
      chk("R1 reset wide", n_code, 12'h000);
      chk("R1 reset byte", b_code, 12'h000);
   endtask

   task automatic t_nibbles;
      nwr(0, 4'b1110, 12'h5A3, 0);
      chk("R3 lsb nibble not on output", n_code, 12'h000);
      nwr(0, 4'b1101, 12'hC7E, 0);
      nwr(0, 4'b1011, 12'h9F1, 0);
      chk("R3 three nibbles staged only", n_code, 12'h000);
      nwr(0, 4'b0111, 12'hFFF, 0);
      chk("R4 second rank load", n_code, 12'h973);
      nwr(0, 4'b1111, 12'h000, 0);
      chk("R4 all enables high no-op", n_code, 12'h973);
   endtask

   task automatic t_cs_block;
      nwr(1, 4'b0000, 12'hFFF, 0);
      chk("R2 cs high", n_code, 12'h973);
      nwr(0, 4'b0000, 12'hEEE, 0, 1'b0);
      chk("R2 strobe low", n_code, 12'h973);
      nwr(0, 4'b0111, 12'h000, 0);
      chk("R2 first rank untouched", n_code, 12'h973);
   endtask

   task automatic t_combined;
      nwr(0, 4'b0110, 12'h005, 0);
      chk("R5 nibble with load", n_code, 12'h975);
      nwr(0, 4'b0000, 12'hABC, 0);
      chk("R5 pass-through", n_code, 12'hABC);
   endtask

   task automatic t_twos;
      nwr(0, 4'b0000, 12'h123, 1);
      chk("R6 msb inverted", n_code, 12'h923);
      nwr(0, 4'b0111, 12'h000, 0);
      chk("R6 straight binary", n_code, 12'h123);
      nwr(0, 4'b0000, 12'h800, 1);
      chk("R6 800h to 000h", n_code, 12'h000);
   endtask

   task automatic t_left;
      bwr(0, 4'b1101, 8'hB0, 0, 0);
      chk("R7 low byte staged", b_code, 12'h000);
      bwr(0, 4'b1110, 8'h5C, 0, 0);
      chk("R7 left-justified word", b_code, 12'h5CB);
   endtask

   task automatic t_right;
      bwr(0, 4'b1101, 8'h34, 1, 0);
      chk("R8 low byte staged", b_code, 12'h5CB);
      bwr(0, 4'b1110, 8'hF2, 1, 0);
      chk("R8 right-justified word", b_code, 12'h234);
   endtask

   task automatic t_byte_noop;
      bwr(0, 4'b1100, 8'hFF, 1, 0);
      bwr(0, 4'b1111, 8'hFF, 0, 0);
      bwr(1, 4'b1110, 8'hFF, 0, 0);
      chk("R9 offsets 00/11 no output change", b_code, 12'h234);
      bwr(0, 4'b0010, 8'h01, 1, 0);
      chk("R9 offsets ignored, upper lines ignored", b_code, 12'h134);
   endtask

   task automatic t_random;
      for (int k = 0; k < 300; k++) begin
         nwr(($urandom % 4) == 0, 4'($urandom), 12'($urandom), 1'($urandom));
         chk("R5 random wide", n_code, nexp);
         bwr(($urandom % 4) == 0, 4'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
         chk("R8 random byte", b_code, bexp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_nibbles();
      t_cs_block();
      t_combined();
      t_twos();
      t_left();
      t_right();
      t_byte_noop();
      t_random();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule